// File: doc/BRIEF.md
# Reloadable Watchdog Timer with Initialization Lock

This block watches that software keeps running after reset. A 16-bit counter advances once every 2 or every 128 clocks, chosen by a select input. Software must strobe the service input before the counter passes its all-ones value. Each service loads the counter's upper byte from an 8-bit reload input, clears its lower byte and restarts the prescaler phase. A larger reload value therefore gives a shorter interval.

If the counter wraps past all ones, the block raises a reset request and drives an active-low reset output for a fixed pulse. When the pulse ends, the block returns to its reset state. The watchdog runs from reset. A disable strobe stops it only while the initialization phase is open. The end-of-initialization strobe closes that phase until the next reset. The reload and select inputs are expected to come from a register held elsewhere, whose reset values are reload 0x00 and divide-by-2. With those values the interval is 65536 × 2 clocks, about 6.55 ms at 20 MHz.

Top module: `wdt_guard`

## Requirements
- R1: After reset, count_o is 0x0000, reset_req_o is 0, reset_no is 1, and the counter is running.
- R2: With prescale_sel_i = 0 the counter advances once every 2 clocks, and with prescale_sel_i = 1 once every 128 clocks. A phase counter steps each clock, and the counter advances on the clock in which the phase reaches divisor − 1.
- R3: A service strobe sampled at a clock edge sets count_o to {reload_i, 8'h00} after that edge and restarts the prescaler phase at 0.
- R4: After a service with no further service, reset_req_o rises after exactly (256 − reload) × 256 × divisor clock edges, counted from the service edge.
- R5: A disable strobe accepted before the lock freezes count_o. No overflow can then occur. A service still loads count_o. Only a reset or an overflow pulse re-enables the counter.
- R6: The end-of-initialization strobe sets a lock that only reset clears. Once the lock is set, disable strobes have no effect. A disable strobe in the same cycle as the end-of-initialization strobe is still accepted.
- R7: On overflow, reset_req_o is 1 for exactly 16 cycles and count_o holds 0x0000. Service and disable strobes are ignored during the pulse. After the pulse, the block is in its reset state: running and unlocked.
- R8: A service strobe in the cycle where the counter would overflow wins. No reset pulse occurs, and the service reload is applied.
- R9: reset_no is always the inverse of reset_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| service_i | input | 1 | Service strobe from software |
| disable_i | input | 1 | Disable request, honored only before lock |
| init_done_i | input | 1 | End-of-initialization strobe, sets the lock |
| reload_i | input | 8 | Upper-byte reload value |
| prescale_sel_i | input | 1 | 0: divide by 2, 1: divide by 128 |
| count_o | output | 16 | Current counter value |
| reset_req_o | output | 1 | Internal reset request, active high |
| reset_no | output | 1 | External reset, active low |

## Verification
The hardest state to reach is a service strobe that lands in exactly the cycle of overflow. The stimulus gets there by servicing with reload 0xFF at divide-by-2, then stepping exactly 511 edges before raising the strobe. A cycle-level reference model then follows long random runs. These runs use high reload values and rare services, so overflows, reset pulses and lock and disable races occur many times. Prescaler changes are applied only together with a service.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int unsigned CNT_W_DEF   = 16;
  localparam int unsigned RLD_W_DEF   = 8;
  localparam int unsigned DIV_LO_DEF  = 2;
  localparam int unsigned DIV_HI_DEF  = 128;
  localparam int unsigned PULSE_DEF   = 16;

  typedef enum logic {
    PSC_FAST = 1'b0,
    PSC_SLOW = 1'b1
  } psc_sel_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_guard_pkg::*;
#(
  parameter int unsigned DIV_LO = DIV_LO_DEF,
  parameter int unsigned DIV_HI = DIV_HI_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic sel_i,
  output logic tick_o
);
  localparam int unsigned PSC_W = $clog2(DIV_HI);
  localparam logic [PSC_W-1:0] LIM_LO = PSC_W'(DIV_LO - 1);
  localparam logic [PSC_W-1:0] LIM_HI = PSC_W'(DIV_HI - 1);

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] lim;
  logic             wrap;

  assign lim    = (psc_sel_e'(sel_i) == PSC_SLOW) ? LIM_HI : LIM_LO;
  assign wrap   = (psc_q >= lim);
  assign tick_o = run_i & ~clr_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    psc_q <= '0;
    else if (clr_i) psc_q <= '0;
    else if (run_i) psc_q <= wrap ? '0 : psc_q + PSC_W'(1);
  end

  // divisors are at least 2, so ticks never come back to back
  assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_guard_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned RLD_W = RLD_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [RLD_W-1:0] reload_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam int unsigned LO_W = CNT_W - RLD_W;

  logic [CNT_W-1:0] cnt_q;

  assign count_o = cnt_q;
  assign ovf_o   = tick_i & ~load_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (load_i)  cnt_q <= {reload_i, {LO_W{1'b0}}};
    else if (tick_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i) |=> (count_o == {$past(reload_i), {LO_W{1'b0}}}));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic restart_i,
  input  logic dis_i,
  input  logic init_i,
  output logic en_o
);
  logic en_q;
  logic lock_q;

  assign en_o = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b1;
      lock_q <= 1'b0;
    end else if (restart_i) begin
      en_q   <= 1'b1;
      lock_q <= 1'b0;
    end else if (!hold_i) begin
      // lock is seen from the register: same-cycle disable still lands
      if (dis_i && !lock_q) en_q <= 1'b0;
      if (init_i)           lock_q <= 1'b1;
    end
  end

  assert_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !restart_i) |=> (en_q == $past(en_q)));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse
  import wdt_guard_pkg::*;
#(
  parameter int unsigned PULSE_LEN = PULSE_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o,
  output logic restart_o
);
  localparam int unsigned PLS_W = $clog2(PULSE_LEN + 1);

  logic [PLS_W-1:0] cnt_q;

  assign active_o  = (cnt_q != '0);
  assign restart_o = (cnt_q == PLS_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (fire_i)   cnt_q <= PLS_W'(PULSE_LEN);
    else if (active_o) cnt_q <= cnt_q - PLS_W'(1);
  end

  assert_pulse_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !fire_i) |=> (cnt_q == $past(cnt_q) - PLS_W'(1)));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int unsigned CNT_W     = CNT_W_DEF,
  parameter int unsigned RLD_W     = RLD_W_DEF,
  parameter int unsigned DIV_LO    = DIV_LO_DEF,
  parameter int unsigned DIV_HI    = DIV_HI_DEF,
  parameter int unsigned PULSE_LEN = PULSE_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             service_i,
  input  logic             disable_i,
  input  logic             init_done_i,
  input  logic [RLD_W-1:0] reload_i,
  input  logic             prescale_sel_i,
  output logic [CNT_W-1:0] count_o,
  output logic             reset_req_o,
  output logic             reset_no
);
  logic active;
  logic restart;
  logic en;
  logic svc;
  logic run;
  logic tick;
  logic ovf;

  assign svc = service_i & ~active;
  assign run = en & ~active;

  wdt_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (active),
    .restart_i (restart),
    .dis_i     (disable_i),
    .init_i    (init_done_i),
    .en_o      (en)
  );

  wdt_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (svc | restart),
    .run_i  (run),
    .sel_i  (prescale_sel_i),
    .tick_o (tick)
  );

  wdt_count #(.CNT_W(CNT_W), .RLD_W(RLD_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (restart),
    .load_i   (svc),
    .reload_i (reload_i),
    .tick_i   (tick),
    .count_o  (count_o),
    .ovf_o    (ovf)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pls (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (ovf),
    .active_o  (active),
    .restart_o (restart)
  );

  assign reset_req_o = active;
  assign reset_no    = ~active;

  assert_svc_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (service_i && !reset_req_o) |=> !reset_req_o);

  assert_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !service_i && !reset_req_o) |=> $stable(count_o));
endmodule

// File: tb/sim_wdt_guard.sv
`timescale 1ns/1ps
module sim_wdt_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        svc = 1'b0, dis = 1'b0, init = 1'b0, sel = 1'b0;
  logic [7:0]  rld = 8'h00;
  logic [15:0] count;
  logic        req, rst_out;

  int checks = 0, errors = 0;
  int m_cnt, m_psc, m_pulse;
  bit m_en, m_lock;

  always #10 clk = ~clk;

  wdt_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .service_i(svc), .disable_i(dis),
    .init_done_i(init), .reload_i(rld), .prescale_sel_i(sel),
    .count_o(count), .reset_req_o(req), .reset_no(rst_out)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_psc = 0; m_pulse = 0; m_en = 1; m_lock = 0;
  endtask

  // reference model advanced once per clock edge from the requirements
  task automatic model_edge();
    int div;
    bit tick;
    if (m_pulse != 0) begin
      if (m_pulse == 1) model_reset();
      else m_pulse--;
    end else begin
      div  = sel ? 128 : 2;
      tick = m_en && !svc && (m_psc >= div - 1);
      if (svc) m_psc = 0;
      else if (m_en) m_psc = tick ? 0 : m_psc + 1;
      if (svc) m_cnt = int'(rld) << 8;
      else if (tick) begin
        if (m_cnt == 16'hFFFF) begin m_cnt = 0; m_pulse = 16; end
        else m_cnt++;
      end
      if (dis && !m_lock) m_en = 0;
      if (init) m_lock = 1;
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1 model_edge();
    @(negedge clk);
    chk(count == 16'(m_cnt), "R3 count vs model", count, m_cnt);
    chk(req == (m_pulse != 0), "R7 reset_req vs model", req, m_pulse != 0);
    chk(rst_out == ~req, "R9 reset_no inverse", rst_out, ~req);
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst_n = 1'b0; svc = 0; dis = 0; init = 0; sel = 0; rld = 8'h00;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic service(input logic [7:0] r, input logic s);
    rld = r; sel = s; svc = 1'b1;
    step();
    svc = 1'b0;
  endtask

  task automatic timeout_len(output int n, input int limit);
    n = 0;
    while (!req && n < limit) begin step(); n++; end
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, w;
    logic [15:0] snap;
    void'($urandom(32'd4711));
    model_reset();
    #5;
    chk(count == 16'h0 && req == 0 && rst_out == 1, "R1 reset state", count, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();
    chk(count == 16'd2, "R1 R2 running after reset, div2", count, 2);

    // R4 timeout with reload 0xFE, divide by 2
    service(8'hFE, 1'b0);
    timeout_len(n, 5000);
    chk(n == 1024, "R4 timeout FE/div2", n, 1024);
    w = 0;
    do begin w++; step(); end while (req && w < 40);
    chk(w == 16, "R7 pulse length", w, 16);
    chk(count == 16'h0, "R7 count after pulse", count, 0);
    step(); step();
    chk(count == 16'h1, "R7 running again after pulse", count, 1);

    // R2 R4 divide by 128, reload 0xFF
    service(8'hFF, 1'b1);
    for (int i = 0; i < 127; i++) step();
    chk(count == 16'hFF00, "R2 no advance before 128", count, 16'hFF00);
    step();
    chk(count == 16'hFF01, "R2 advance at 128", count, 16'hFF01);
    timeout_len(n, 40000);
    chk(n == 32768 - 128, "R4 timeout FF/div128", n, 32768 - 128);
    while (req) step();

    // R8 service in the overflow cycle
    service(8'hFF, 1'b0);
    for (int i = 0; i < 511; i++) step();
    chk(count == 16'hFFFF && req == 0, "R8 at edge of overflow", count, 16'hFFFF);
    rld = 8'hFF; svc = 1'b1; step(); svc = 1'b0;
    chk(req == 0, "R8 no reset when service wins", req, 0);
    chk(count == 16'hFF00, "R8 reload applied", count, 16'hFF00);

    // R5 disable before lock
    hard_reset();
    dis = 1'b1; step(); dis = 1'b0;
    snap = count;
    for (int i = 0; i < 300; i++) step();
    chk(count == snap, "R5 frozen when disabled", count, snap);
    service(8'h12, 1'b0);
    for (int i = 0; i < 50; i++) step();
    chk(count == 16'h1200 && req == 0, "R5 service loads, still frozen", count, 16'h1200);

    // R6 lock ignores later disable
    hard_reset();
    init = 1'b1; step(); init = 1'b0;
    dis = 1'b1; step(); dis = 1'b0;
    service(8'hFF, 1'b0);
    timeout_len(n, 2000);
    chk(n == 512, "R6 disable ignored after lock", n, 512);
    while (req) step();
    // R7 lock cleared by pulse: disable works again
    dis = 1'b1; step(); dis = 1'b0;
    snap = count;
    for (int i = 0; i < 20; i++) step();
    chk(count == snap, "R7 lock cleared after pulse", count, snap);

    // R6 same-cycle disable and init
    hard_reset();
    init = 1'b1; dis = 1'b1; step(); init = 1'b0; dis = 1'b0;
    snap = count;
    for (int i = 0; i < 20; i++) step();
    chk(count == snap, "R6 same-cycle disable accepted", count, snap);

    // random phase against the model
    hard_reset();
    for (int i = 0; i < 60000; i++) begin
      svc  = ($urandom_range(0, 999) < 2);
      if (svc) begin
        rld = 8'(8'hF8 + $urandom_range(0, 7));
        sel = ($urandom_range(0, 9) == 0);
      end
      dis  = ($urandom_range(0, 4999) == 0);
      init = ($urandom_range(0, 999) == 0);
      step();
      if ($urandom_range(0, 19999) == 0) hard_reset();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule